// File: doc/BRIEF.md
# Erase Unlock Command Sequencer

This block is the mode controller of an electrically erasable, byte-wide read-only memory. It observes write cycles on the memory's bus: an address and a data byte, each qualified by a latch-enable pulse. A cycle counts as a write only while the high-voltage-present flag is set. The pulse width is measured in clock cycles, and the address, data and high-voltage flags are captured on the first high cycle of latch enable. Each write is acted on in the cycle after latch enable falls.

A chip erase starts in one of two ways. The first is a two-write unlock, in which each write must carry the correct address, the correct data and the correct pulse width. The second is a single write taken while a high voltage is flagged on address pin 9, with a fixed pattern on address bits 8, 10 and 11. Any other write is a program cycle. The array itself lies outside this block: it applies new = old AND data at the strobed address.

After an erase or a program, the block moves by itself into the matching verify mode. It stays there until a power-down reset.

Top module: `erase_unlock_seq`

## Requirements
- R1: After reset, `mode` is 0 (read) and both `erase_all` and `prog_byte` are low.
- R2: A write of data 0xAA to address 0x5555 with a short pulse, followed directly by a write of 0x10 to 0x2AAA with a long pulse, raises `erase_all` for exactly one cycle, with `mode` = 3 (erase) in that cycle. The first write gives no strobe and leaves `mode` at 0.
- R3: A short pulse is accepted when its width in cycles lies in SHORT_CYC±TOL_CYC, and a long pulse when it lies in LONG_CYC±TOL_CYC, bounds included. A first unlock write whose width is outside its window becomes a program cycle.
- R4: If the write that directly follows an accepted first unlock step has the wrong address, data or width, the sequence aborts to idle and that write becomes a program cycle.
- R5: A write that neither advances the unlock nor is an alternate erase raises `prog_byte` for one cycle, with `mode` = 1 (program) and `prog_addr`/`prog_data` equal to the captured address and data.
- R6: One cycle after `mode` = 3 it becomes 4 (erase verify). One cycle after `mode` = 1 it becomes 2 (program verify).
- R7: Modes 2 and 4 persist. In them, further writes, including a full unlock sequence, produce no strobe and leave `mode` unchanged. Only reset returns `mode` to 0.
- R8: A latch-enable pulse captured with `hv_en` low is ignored: no strobe, no mode change, and the unlock step already reached is kept.
- R9: A write with `a9_hv` = 1, address bit 10 = 1 and address bits 8 and 11 = 0 raises `erase_all` regardless of its width. With address bit 8 = 1 the same write is a program cycle instead.
- R10: `erase_all` and `prog_byte` are never high together. A strobe appears only in the cycle after latch enable fell, having been high the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-down reset |
| le | input | 1 | Latch enable; its high time is the write pulse |
| hv_en | input | 1 | High voltage present on the output-enable/program pin |
| a9_hv | input | 1 | High voltage present on address pin 9 |
| addr | input | 16 | Write address |
| data | input | 8 | Write data |
| mode | output | 3 | 0 read, 1 program, 2 program verify, 3 erase, 4 erase verify |
| erase_all | output | 1 | One-cycle chip erase strobe |
| prog_byte | output | 1 | One-cycle program strobe |
| prog_addr | output | 16 | Address of the byte being programmed |
| prog_data | output | 8 | Data to AND into that byte |

## Verification
A wrong unlock state shows at the ports on the second write of a sequence. That write either raises `erase_all` or `prog_byte` when it should not, or fails to raise the one it should, one cycle after latch enable falls. A miscounted pulse width shows in the same way at the boundary widths SHORT_CYC±TOL_CYC and LONG_CYC±TOL_CYC and just outside them. A mode register that leaves a verify mode, or that fails to reach one, shows on `mode` one cycle after a strobe, or on any later write.

// File: rtl/erase_seq_pkg.sv
// Shared types and command constants for the erase unlock sequencer.
// Assumes a 16-bit address space and byte-wide data.
package erase_seq_pkg;

    typedef enum logic [2:0] {
        MODE_READ    = 3'd0,
        MODE_PROG    = 3'd1,
        MODE_PVERIFY = 3'd2,
        MODE_ERASE   = 3'd3,
        MODE_EVERIFY = 3'd4
    } mode_e;

    localparam logic [15:0] STEP1_ADDR = 16'h5555;
    localparam logic [7:0]  STEP1_DATA = 8'hAA;
    localparam logic [15:0] STEP2_ADDR = 16'h2AAA;
    localparam logic [7:0]  STEP2_DATA = 8'h10;

endpackage

// File: rtl/le_pulse_meter.sv
// Measures the width of each latch-enable pulse in clock cycles and captures
// the bus on the first high cycle. Raises done for one cycle when le falls.
// Assumes addr, data and the flags are stable from the first high cycle on.
module le_pulse_meter #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              le,
    input  logic              hv_en,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              done,
    output logic [CNT_W-1:0]  width,
    output logic              cap_hv,
    output logic              cap_a9,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic le_q;
    logic rise;

    assign rise = le & ~le_q;
    assign done = ~le & le_q;

    // Delay latch enable by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) le_q <= 1'b0;
        else        le_q <= le;
    end

    // Count high cycles of the pulse, saturating at the counter maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)                      width <= '0;
        else if (rise)                   width <= CNT_W'(1);
        else if (le && width != CNT_MAX) width <= width + CNT_W'(1);
    end

    // Capture the bus and the voltage flags on the first high cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_hv   <= 1'b0;
            cap_a9   <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
        end else if (rise) begin
            cap_hv   <= hv_en;
            cap_a9   <= a9_hv;
            cap_addr <= addr;
            cap_data <= data;
        end
    end
endmodule

// File: rtl/unlock_tracker.sv
// Classifies each finished write as an unlock step, an erase or a program.
// Holds one bit of progress: first unlock step accepted. Writes arrive only
// when write_ok is high (high voltage captured and mode is read).
module unlock_tracker #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 6,
    parameter int SHORT_CYC = 8,
    parameter int LONG_CYC  = 40,
    parameter int TOL_CYC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic              write_ok,
    input  logic [CNT_W-1:0]  width,
    input  logic              cap_a9,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [DATA_W-1:0] cap_data,
    output logic              erase_req,
    output logic              prog_req
);
    import erase_seq_pkg::*;

    localparam logic [CNT_W-1:0] SHORT_LO = CNT_W'(SHORT_CYC - TOL_CYC);
    localparam logic [CNT_W-1:0] SHORT_HI = CNT_W'(SHORT_CYC + TOL_CYC);
    localparam logic [CNT_W-1:0] LONG_LO  = CNT_W'(LONG_CYC - TOL_CYC);
    localparam logic [CNT_W-1:0] LONG_HI  = CNT_W'(LONG_CYC + TOL_CYC);

    logic armed;
    logic fire;
    logic short_ok, long_ok;
    logic step1_hit, step2_hit, alt_hit;

    assign fire     = done & write_ok;
    assign short_ok = (width >= SHORT_LO) && (width <= SHORT_HI);
    assign long_ok  = (width >= LONG_LO) && (width <= LONG_HI);

    assign step1_hit = short_ok && cap_addr[15:0] == STEP1_ADDR && cap_data[7:0] == STEP1_DATA;
    assign step2_hit = long_ok && cap_addr[15:0] == STEP2_ADDR && cap_data[7:0] == STEP2_DATA;
    assign alt_hit   = cap_a9 && cap_addr[10] && !cap_addr[8] && !cap_addr[11];

    // Decide the action for the write that just finished.
    always_comb begin
        erase_req = 1'b0;
        prog_req  = 1'b0;
        if (fire) begin
            if (alt_hit)                erase_req = 1'b1;
            else if (armed && step2_hit) erase_req = 1'b1;
            else if (!armed && step1_hit) prog_req = 1'b0;
            else                        prog_req  = 1'b1;
        end
    end

    // Track unlock progress; any write other than a valid first step clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)    armed <= 1'b0;
        else if (fire) armed <= !armed && !alt_hit && step1_hit;
    end
endmodule

// File: rtl/mode_keeper.sv
// Holds the operating mode and issues the one-cycle erase and program
// strobes. Erase and program step into their verify modes on the next
// cycle; verify modes are left only through reset.
module mode_keeper #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 erase_req,
    input  logic                 prog_req,
    input  logic [ADDR_W-1:0]    cap_addr,
    input  logic [DATA_W-1:0]    cap_data,
    output erase_seq_pkg::mode_e mode,
    output logic                 in_read,
    output logic                 erase_all,
    output logic                 prog_byte,
    output logic [ADDR_W-1:0]    prog_addr,
    output logic [DATA_W-1:0]    prog_data
);
    import erase_seq_pkg::*;

    assign in_read = (mode == MODE_READ);

    // Advance the mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_READ;
        end else begin
            case (mode)
                MODE_READ:  if (erase_req)     mode <= MODE_ERASE;
                            else if (prog_req) mode <= MODE_PROG;
                MODE_ERASE: mode <= MODE_EVERIFY;
                MODE_PROG:  mode <= MODE_PVERIFY;
                default:    mode <= mode;
            endcase
        end
    end

    // Generate the strobes and hold the programmed address and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_all <= 1'b0;
            prog_byte <= 1'b0;
            prog_addr <= '0;
            prog_data <= '0;
        end else begin
            erase_all <= in_read && erase_req;
            prog_byte <= in_read && prog_req && !erase_req;
            if (in_read && prog_req) begin
                prog_addr <= cap_addr;
                prog_data <= cap_data;
            end
        end
    end
endmodule

// File: rtl/erase_unlock_seq.sv
// Top of the erase unlock sequencer: pulse meter, unlock tracker and
// mode keeper. Assumes voltage levels arrive as clean synchronous flags.
module erase_unlock_seq #(
    parameter int SHORT_CYC = 8,
    parameter int LONG_CYC  = 40,
    parameter int TOL_CYC   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        le,
    input  logic        hv_en,
    input  logic        a9_hv,
    input  logic [15:0] addr,
    input  logic [7:0]  data,
    output logic [2:0]  mode,
    output logic        erase_all,
    output logic        prog_byte,
    output logic [15:0] prog_addr,
    output logic [7:0]  prog_data
);
    import erase_seq_pkg::*;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int CNT_W  = $clog2(LONG_CYC + TOL_CYC + 2) + 1;

    logic              done;
    logic [CNT_W-1:0]  width;
    logic              cap_hv, cap_a9;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;
    logic              erase_req, prog_req, in_read;
    mode_e             mode_q;

    assign mode = mode_q;

    le_pulse_meter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_meter (
        .clk(clk), .rst_n(rst_n), .le(le), .hv_en(hv_en), .a9_hv(a9_hv),
        .addr(addr), .data(data), .done(done), .width(width),
        .cap_hv(cap_hv), .cap_a9(cap_a9), .cap_addr(cap_addr), .cap_data(cap_data)
    );

    unlock_tracker #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC), .TOL_CYC(TOL_CYC)
    ) u_track (
        .clk(clk), .rst_n(rst_n), .done(done), .write_ok(cap_hv && in_read),
        .width(width), .cap_a9(cap_a9), .cap_addr(cap_addr), .cap_data(cap_data),
        .erase_req(erase_req), .prog_req(prog_req)
    );

    mode_keeper #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mode (
        .clk(clk), .rst_n(rst_n), .erase_req(erase_req), .prog_req(prog_req),
        .cap_addr(cap_addr), .cap_data(cap_data), .mode(mode_q), .in_read(in_read),
        .erase_all(erase_all), .prog_byte(prog_byte),
        .prog_addr(prog_addr), .prog_data(prog_data)
    );
endmodule

// File: rtl/erase_unlock_seq_checker.sv
// Port-level properties of the erase unlock sequencer, bound to the top.
module erase_unlock_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       le,
    input logic [2:0] mode,
    input logic       erase_all,
    input logic       prog_byte
);
    // R10: the two strobes never overlap.
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(erase_all && prog_byte));

    // R10: a strobe follows a falling latch enable.
    p_strobe_after_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_all || prog_byte) |-> (!$past(le) && $past(le, 2)));

    // R2: the erase strobe coincides with the erase mode.
    p_erase_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        erase_all |-> mode == 3'd3);

    // R5: the program strobe coincides with the program mode.
    p_prog_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_byte |-> mode == 3'd1);

    // R6: erase and program move on to their verify modes.
    p_erase_verify_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 3'd3 |=> mode == 3'd4);
    p_prog_verify_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 3'd1 |=> mode == 3'd2);

    // R7: verify modes hold and issue no strobes.
    p_sticky_ev_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 3'd4 |=> (mode == 3'd4 && !erase_all && !prog_byte));
    p_sticky_pv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 3'd2 |=> (mode == 3'd2 && !erase_all && !prog_byte));
endmodule

bind erase_unlock_seq erase_unlock_seq_checker u_checker (
    .clk(clk), .rst_n(rst_n), .le(le), .mode(mode),
    .erase_all(erase_all), .prog_byte(prog_byte)
);

// File: tb/erase_unlock_seq_bench.sv
// Directed bench for the erase unlock sequencer: one task per scenario.
module erase_unlock_seq_bench;
    localparam int SHORT = 8;
    localparam int LONG  = 40;
    localparam int TOL   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        le = 1'b0;
    logic        hv_en = 1'b0;
    logic        a9_hv = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  data = '0;
    logic [2:0]  mode;
    logic        erase_all, prog_byte;
    logic [15:0] prog_addr;
    logic [7:0]  prog_data;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    logic        s_erase, s_prog;
    logic [2:0]  s_mode, n_mode;
    logic [15:0] s_paddr;
    logic [7:0]  s_pdata;

    always #5 clk = ~clk;

    erase_unlock_seq #(.SHORT_CYC(SHORT), .LONG_CYC(LONG), .TOL_CYC(TOL)) u_erase_unlock_seq (
        .clk(clk), .rst_n(rst_n), .le(le), .hv_en(hv_en), .a9_hv(a9_hv),
        .addr(addr), .data(data), .mode(mode), .erase_all(erase_all),
        .prog_byte(prog_byte), .prog_addr(prog_addr), .prog_data(prog_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        le = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One write pulse of w cycles; samples the strobe cycle and the cycle after.
    task automatic wr(input logic [15:0] a, input logic [7:0] d, input int w,
                      input bit hv, input bit a9);
        @(negedge clk);
        addr = a; data = d; hv_en = hv; a9_hv = a9; le = 1'b1;
        repeat (w) @(negedge clk);
        le = 1'b0;
        @(posedge clk); #1;
        s_erase = erase_all; s_prog = prog_byte; s_mode = mode;
        s_paddr = prog_addr; s_pdata = prog_data;
        @(posedge clk); #1;
        n_mode = mode;
        hv_en = 1'b0; a9_hv = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        check(mode == 3'd0, "R1 mode", mode, 0);
        check(!erase_all && !prog_byte, "R1 strobes", {erase_all, prog_byte}, 0);
    endtask

    task automatic t_unlock_and_sticky();
        do_reset();
        wr(16'h5555, 8'hAA, SHORT, 1, 0);
        check(!s_erase && !s_prog && n_mode == 0, "R2 step1 silent", {s_erase, s_prog, n_mode}, 0);
        wr(16'h2AAA, 8'h10, LONG, 1, 0);
        check(s_erase && s_mode == 3, "R2 erase strobe", {s_erase, s_mode}, 'hB);
        check(!s_prog, "R10 exclusive", s_prog, 0);
        check(n_mode == 4, "R6 erase verify", n_mode, 4);
        check(!erase_all, "R2 single cycle", erase_all, 0);
        wr(16'h1234, 8'h55, SHORT, 1, 0);
        check(!s_prog && !s_erase && s_mode == 4, "R7 write ignored", {s_erase, s_prog, s_mode}, 4);
        wr(16'h5555, 8'hAA, SHORT, 1, 0);
        wr(16'h2AAA, 8'h10, LONG, 1, 0);
        check(!s_erase && n_mode == 4, "R7 unlock ignored", {s_erase, n_mode}, 4);
        do_reset();
        #1;
        check(mode == 0, "R7 reset to read", mode, 0);
    endtask

    task automatic t_tolerance();
        do_reset();
        wr(16'h5555, 8'hAA, SHORT - TOL, 1, 0);
        wr(16'h2AAA, 8'h10, LONG + TOL, 1, 0);
        check(s_erase, "R3 edge widths accepted", s_erase, 1);
        do_reset();
        wr(16'h5555, 8'hAA, SHORT + TOL + 1, 1, 0);
        check(s_prog && !s_erase, "R3 wide step1 programs", {s_erase, s_prog}, 1);
        check(s_paddr == 16'h5555 && s_pdata == 8'hAA, "R3 program target",
              {s_paddr, s_pdata}, 'h5555AA);
    endtask

    task automatic t_abort();
        do_reset();
        wr(16'h5555, 8'hAA, SHORT, 1, 0);
        wr(16'h2AAA, 8'h11, LONG, 1, 0);
        check(s_prog && !s_erase, "R4 bad data aborts", {s_erase, s_prog}, 1);
        do_reset();
        wr(16'h5555, 8'hAA, SHORT, 1, 0);
        wr(16'h2AAA, 8'h10, LONG - TOL - 1, 1, 0);
        check(s_prog && !s_erase, "R4 short step2 aborts", {s_erase, s_prog}, 1);
    endtask

    task automatic t_program();
        do_reset();
        wr(16'hBEEF, 8'h3C, 5, 1, 0);
        check(s_prog && s_mode == 1, "R5 program strobe", {s_prog, s_mode}, 'h9);
        check(s_paddr == 16'hBEEF && s_pdata == 8'h3C, "R5 program target",
              {s_paddr, s_pdata}, 'hBEEF3C);
        check(n_mode == 2, "R6 program verify", n_mode, 2);
    endtask

    task automatic t_inhibit();
        do_reset();
        wr(16'h0F0F, 8'h00, 5, 0, 0);
        check(!s_prog && !s_erase && n_mode == 0, "R8 no hv ignored", {s_erase, s_prog, n_mode}, 0);
        wr(16'h5555, 8'hAA, SHORT, 1, 0);
        wr(16'h7777, 8'h00, 4, 0, 0);
        wr(16'h2AAA, 8'h10, LONG, 1, 0);
        check(s_erase, "R8 unlock kept", s_erase, 1);
    endtask

    task automatic t_alt();
        do_reset();
        wr(16'h0400, 8'h00, 3, 1, 1);
        check(s_erase && s_mode == 3, "R9 alternate erase", {s_erase, s_mode}, 'hB);
        do_reset();
        wr(16'h0500, 8'h00, 3, 1, 1);
        check(s_prog && !s_erase, "R9 A8 high programs", {s_erase, s_prog}, 1);
    endtask

    initial begin
        #1500000;
        if (!ended) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_unlock_and_sticky();
        t_tolerance();
        t_abort();
        t_program();
        t_inhibit();
        t_alt();
        ended = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule